// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Two-Line Victim Buffer

This block is a read-only data cache controller. The main store is a direct-mapped array of lines. Beside it sits a fully associative buffer of two lines. That buffer keeps the lines most recently pushed out of the main array, which gives conflicting addresses a little associativity without a second way.

A processor issues a word address on a valid/ready port. The block answers with a one-cycle done pulse and the selected 32-bit word. A request that hits the main array finishes in the cycle after it is accepted. On a main-array miss the buffer is probed. If the buffer holds the line, the buffer line and the main-array line at that index change places, and the word is returned. If the buffer also misses, the whole line is requested over a line-wide memory port, and the answer is both written into the array and returned. Three event counters separate main hits, buffer hits and full misses, so the average access time can be computed from them.

Top module: `dm_victim_cache`

## Requirements
- R1: A main-array hit asserts rsp_done in the first cycle after acceptance. rsp_data is word w of the line, where w is req_waddr[2:0] for the default 32-byte line, and word w sits at line bits [32w+31:32w].
- R2: A main-array miss that hits the victim buffer asserts rsp_done in the third cycle after acceptance, with the correct word, and issues no memory request.
- R3: A miss in both stores raises mem_req_valid for one cycle, in the second cycle after acceptance. It carries the line address, req_waddr[ADDR_W-3:3]. rsp_done rises in the cycle in which mem_rsp_valid is presented, returning the word from mem_rsp_line. With a memory answering 40 cycles after the request, this gives 42 cycles in total.
- R4: The main index is line-address bits [9:0] (default sizes), so lines whose byte addresses differ by 32 KB collide. A fill that replaces a valid line moves that line into the victim buffer.
- R5: The buffer keeps only the two most recently discarded lines. A third eviction drops the oldest entry, and a later access to that line is a full miss.
- R6: After a buffer hit, the requested line sits in the main array, so the next access to it is a main hit. The line it displaced sits in the buffer, so an access to that line is a buffer hit.
- R7: The buffer slot that received the displaced line in an exchange becomes the most recent. The next eviction therefore overwrites the other slot.
- R8: Each completed access adds one to exactly one of cnt_prim_hit, cnt_vict_hit and cnt_miss, according to its kind. The counters do not change in any other cycle.
- R9: req_ready is low from the cycle after acceptance through the done cycle, and high again in the cycle after rsp_done.
- R10: While rst_n is low, req_ready is low and all counters are zero. req_ready rises no later than the third cycle after release. Reset empties both stores, so the first access to any address is a full miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_waddr | input | ADDR_W-2 | Word address of the read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Word read, valid with rsp_done |
| mem_req_valid | output | 1 | Line fetch request, one cycle |
| mem_req_line | output | ADDR_W-log2(LINE_BYTES) | Line address to fetch |
| mem_rsp_valid | input | 1 | Fetched line present, one cycle |
| mem_rsp_line | input | LINE_BYTES*8 | Fetched line data |
| cnt_prim_hit | output | CNT_W | Main-array hits |
| cnt_vict_hit | output | CNT_W | Victim-buffer hits |
| cnt_miss | output | CNT_W | Full misses |

## Verification
The hardest state to reach from the ports is a victim buffer whose recency order differs from plain insertion order. That order only arises when an exchange has refreshed a slot, and it shows only when a later eviction picks between the two slots. The stimulus cycles four lines through one main index with mixed exchanges and fills. The sequence is chosen so that the surviving line depends on the recency update after an exchange. The outcome is then read through the latency of a later access, 3 cycles for a buffer hit against 42 for a miss.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_PROBE,
    ST_SWAP,
    ST_FETCH
  } dmvc_state_e;

  localparam int unsigned EV_PRIM   = 0;
  localparam int unsigned EV_VICT   = 1;
  localparam int unsigned EV_MISS   = 2;
  localparam int unsigned EV_NUM    = 3;
  localparam int unsigned VB_SLOTS  = 2;
endpackage

// File: rtl/dmvc_line_store.sv
module dmvc_line_store #(
  parameter int unsigned SETS   = 1024,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned TAG_W  = 17,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/dmvc_victim_buf.sv
module dmvc_victim_buf
  import dmvc_pkg::*;
#(
  parameter int unsigned LA_W   = 27,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   lk_addr,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  input  logic              wr_en,
  input  logic              wr_at_hit,
  input  logic              wr_valid,
  input  logic [LA_W-1:0]   wr_addr,
  input  logic [LINE_W-1:0] wr_line
);
  logic [VB_SLOTS-1:0] match;
  logic [LINE_W-1:0]   ent_line [VB_SLOTS];
  logic                hit_slot;
  logic                old_q;
  logic                wr_slot;

  assign hit_slot = match[1];
  assign hit      = |match;
  assign hit_line = match[1] ? ent_line[1] : ent_line[0];
  // an exchange reuses the slot that hit; a plain eviction replaces the older slot
  assign wr_slot  = wr_at_hit ? hit_slot : old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= 1'b0;
    end else if (wr_en) begin
      old_q <= ~wr_slot;
    end
  end

  for (genvar e = 0; e < VB_SLOTS; e++) begin : g_ent
    logic              vld_q;
    logic [LA_W-1:0]   la_q;
    logic [LINE_W-1:0] dat_q;
    logic              sel;

    assign sel = wr_en && (wr_slot == 1'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (sel) begin
        vld_q <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        la_q  <= wr_addr;
        dat_q <= wr_line;
      end
    end

    assign match[e]    = vld_q && (la_q == lk_addr);
    assign ent_line[e] = dat_q;
  end
endmodule

// File: rtl/dmvc_event_cnt.sv
module dmvc_event_cnt #(
  parameter int unsigned NUM   = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM-1:0]       ev,
  output logic [NUM*CNT_W-1:0] cnt_flat
);
  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    logic [CNT_W-1:0] c_d;

    always_comb c_d = c_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
      end else if (ev[i]) begin
        c_q <= c_d;
      end
    end

    assign cnt_flat[i*CNT_W +: CNT_W] = c_q;
  end
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import dmvc_pkg::*;
#(
  parameter int unsigned CACHE_BYTES = 32768,
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [ADDR_W-3:0]                     req_waddr,
  output logic                                  rsp_done,
  output logic [31:0]                           rsp_data,
  output logic                                  mem_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  mem_req_line,
  input  logic                                  mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]               mem_rsp_line,
  output logic [CNT_W-1:0]                      cnt_prim_hit,
  output logic [CNT_W-1:0]                      cnt_vict_hit,
  output logic [CNT_W-1:0]                      cnt_miss
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LINE_W = LINE_BYTES * 8;
  localparam int unsigned SETS   = CACHE_BYTES / LINE_BYTES;
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WSEL_W = OFF_W - 2;
  localparam int unsigned LA_W   = ADDR_W - OFF_W;
  localparam int unsigned TAG_W  = LA_W - IDX_W;
  localparam int unsigned WA_W   = ADDR_W - 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe_q[1];

  dmvc_state_e       state_q, state_d;
  logic [WA_W-1:0]   addr_q;
  logic              addr_en;

  logic [WSEL_W-1:0] wsel;
  logic [LA_W-1:0]   line_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;

  logic              prim_valid;
  logic [TAG_W-1:0]  prim_tag;
  logic [LINE_W-1:0] prim_line;
  logic              prim_hit;
  logic              prim_we;
  logic [LINE_W-1:0] prim_wline;

  logic              vb_hit;
  logic [LINE_W-1:0] vb_line;
  logic              vb_we;
  logic              vb_at_hit;

  logic [LINE_W-1:0] ret_line;
  logic [EV_NUM-1:0] ev;
  logic [EV_NUM*CNT_W-1:0] cnt_flat;

  assign wsel      = addr_q[WSEL_W-1:0];
  assign line_addr = addr_q[WA_W-1:WSEL_W];
  assign idx       = line_addr[IDX_W-1:0];
  assign tag       = line_addr[LA_W-1:IDX_W];
  assign prim_hit  = prim_valid && (prim_tag == tag);

  dmvc_line_store #(
    .SETS  (SETS),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_idx  (idx),
    .rd_valid(prim_valid),
    .rd_tag  (prim_tag),
    .rd_line (prim_line),
    .wr_en   (prim_we),
    .wr_idx  (idx),
    .wr_tag  (tag),
    .wr_line (prim_wline)
  );

  dmvc_victim_buf #(
    .LA_W  (LA_W),
    .LINE_W(LINE_W)
  ) u_vbuf (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .lk_addr  (line_addr),
    .hit      (vb_hit),
    .hit_line (vb_line),
    .wr_en    (vb_we),
    .wr_at_hit(vb_at_hit),
    .wr_valid (prim_valid),
    .wr_addr  ({prim_tag, idx}),
    .wr_line  (prim_line)
  );

  dmvc_event_cnt #(
    .NUM  (EV_NUM),
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ev      (ev),
    .cnt_flat(cnt_flat)
  );

  assign cnt_prim_hit = cnt_flat[EV_PRIM*CNT_W +: CNT_W];
  assign cnt_vict_hit = cnt_flat[EV_VICT*CNT_W +: CNT_W];
  assign cnt_miss     = cnt_flat[EV_MISS*CNT_W +: CNT_W];

  always_comb begin
    state_d       = state_q;
    addr_en       = 1'b0;
    req_ready     = (state_q == ST_IDLE) && rst_i_n;
    rsp_done      = 1'b0;
    ret_line      = prim_line;
    prim_we       = 1'b0;
    prim_wline    = mem_rsp_line;
    vb_we         = 1'b0;
    vb_at_hit     = 1'b0;
    mem_req_valid = 1'b0;
    ev            = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_en = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (prim_hit) begin
          rsp_done    = 1'b1;
          ev[EV_PRIM] = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (vb_hit) begin
          state_d = ST_SWAP;
        end else begin
          mem_req_valid = 1'b1;
          state_d       = ST_FETCH;
        end
      end
      ST_SWAP: begin
        // the buffer still holds the line: its contents do not change during the probe
        rsp_done    = 1'b1;
        ret_line    = vb_line;
        prim_we     = 1'b1;
        prim_wline  = vb_line;
        vb_we       = 1'b1;
        vb_at_hit   = 1'b1;
        ev[EV_VICT] = 1'b1;
        state_d     = ST_IDLE;
      end
      ST_FETCH: begin
        if (mem_rsp_valid) begin
          rsp_done    = 1'b1;
          ret_line    = mem_rsp_line;
          prim_we     = 1'b1;
          vb_we       = prim_valid;
          ev[EV_MISS] = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      addr_q <= req_waddr;
    end
  end

  assign mem_req_line = line_addr;
  assign rsp_data     = ret_line[wsel*WORD_W +: WORD_W];
endmodule

// File: rtl/dmvc_sva.sv
module dmvc_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             mem_req_valid,
  input logic [CNT_W-1:0] cnt_prim_hit,
  input logic [CNT_W-1:0] cnt_vict_hit,
  input logic [CNT_W-1:0] cnt_miss
);
  logic [CNT_W-1:0] tot;
  assign tot = cnt_prim_hit + cnt_vict_hit + cnt_miss;

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);

  assert_no_fetch_in_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_req_valid);

  assert_fetch_not_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_done);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (tot == CNT_W'($past(tot) + 1'b1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |=> $stable(tot));
endmodule

bind dm_victim_cache dmvc_sva #(.CNT_W(CNT_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .mem_req_valid(mem_req_valid),
  .cnt_prim_hit (cnt_prim_hit),
  .cnt_vict_hit (cnt_vict_hit),
  .cnt_miss     (cnt_miss)
);

// File: tb/dm_victim_cache_tb_top.sv
`timescale 1ns/1ps
module dm_victim_cache_tb_top;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned LINE_B  = 32;
  localparam int unsigned LINE_W  = LINE_B * 8;
  localparam int unsigned LA_W    = ADDR_W - 5;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned MEM_LAT = 40;
  localparam int unsigned NVEC    = 16;

  // kind: 0 main hit, 1 victim hit, 2 full miss ; low 32 bits byte address
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd2, 32'h0000_1004},  // cold miss          R10
    {2'd0, 32'h0000_1008},  // same line          R1
    {2'd2, 32'h0000_9004},  // collides, A out    R4
    {2'd1, 32'h0000_101C},  // A back by swap     R2
    {2'd0, 32'h0000_1000},  // A now in main      R6
    {2'd1, 32'h0000_9010},  // B back by swap     R6
    {2'd2, 32'h0001_1000},  // C, B out
    {2'd2, 32'h0001_9000},  // D, C out, A drop   R5
    {2'd2, 32'h0000_1000},  // A gone             R5
    {2'd1, 32'h0001_1000},  // C swap, A recent   R7
    {2'd2, 32'h0000_9000},  // B gone, D dropped  R7
    {2'd1, 32'h0000_1000},  // A survived         R7
    {2'd2, 32'h0001_9000},  // D gone             R7
    {2'd2, 32'h0000_2040},  // other index
    {2'd1, 32'h0000_9008},  // B still buffered   R4
    {2'd0, 32'h0000_2044}   // other index hit    R1
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-3:0] req_waddr;
  logic              rsp_done;
  logic [31:0]       rsp_data;
  logic              mem_req_valid;
  logic [LA_W-1:0]   mem_req_line;
  logic              mem_rsp_valid;
  logic [LINE_W-1:0] mem_rsp_line;
  logic [CNT_W-1:0]  cnt_prim_hit;
  logic [CNT_W-1:0]  cnt_vict_hit;
  logic [CNT_W-1:0]  cnt_miss;

  int errors;
  int checks;
  int mem_req_count;
  logic [LA_W-1:0] last_req;

  dm_victim_cache #(
    .CACHE_BYTES(32768),
    .LINE_BYTES (LINE_B),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_waddr    (req_waddr),
    .rsp_done     (rsp_done),
    .rsp_data     (rsp_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_line (mem_req_line),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line (mem_rsp_line),
    .cnt_prim_hit (cnt_prim_hit),
    .cnt_vict_hit (cnt_vict_hit),
    .cnt_miss     (cnt_miss)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [LA_W-1:0] la, input logic [2:0] w);
    return ({la, w} ^ 32'h5A00_0000);
  endfunction

  function automatic logic [LINE_W-1:0] make_line(input logic [LA_W-1:0] la);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = mem_word(la, 3'(w));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: answers MEM_LAT cycles after the request cycle
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_line  = '0;
    mem_req_count = 0;
    last_req      = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        mem_req_count++;
        last_req = mem_req_line;
        repeat (MEM_LAT) @(posedge clk);
        mem_rsp_valid <= 1'b1;
        mem_rsp_line  <= make_line(last_req);
        @(posedge clk);
        mem_rsp_valid <= 1'b0;
      end
    end
  end

  task automatic do_access(input logic [31:0] baddr, input int kind, input string req);
    int lat;
    int reqs0;
    int exp_lat;
    logic [31:0] got;
    exp_lat = (kind == 0) ? 1 : (kind == 1) ? 3 : 2 + MEM_LAT;
    reqs0 = mem_req_count;
    @(negedge clk);
    req_valid = 1'b1;
    req_waddr = baddr[31:2];
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got = rsp_data;
    chk(lat == exp_lat, req, "latency", lat, exp_lat);
    chk(got == mem_word(baddr[31:5], baddr[4:2]), req, "data", got,
        mem_word(baddr[31:5], baddr[4:2]));
    chk(req_ready == 1'b0, "R9", "ready at done", req_ready, 0);
    if (kind == 2) begin
      chk(mem_req_count == reqs0 + 1, "R3", "fetch count", mem_req_count - reqs0, 1);
      chk(last_req == baddr[31:5], "R3", "fetch line", last_req, baddr[31:5]);
    end else begin
      chk(mem_req_count == reqs0, "R2", "no fetch", mem_req_count - reqs0, 0);
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors    = 0;
    checks    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_waddr = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
    chk(cnt_prim_hit == 0 && cnt_vict_hit == 0 && cnt_miss == 0, "R10", "counters in reset",
        cnt_prim_hit + cnt_vict_hit + cnt_miss, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after release", req_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      do_access(VEC[i][31:0], int'(VEC[i][33:32]), $sformatf("vec%0d R1/R2/R3", i));
    end

    // R8: totals by kind over the table
    @(negedge clk);
    chk(cnt_prim_hit == 3, "R8", "main hit count", cnt_prim_hit, 3);
    chk(cnt_vict_hit == 5, "R8", "victim hit count", cnt_vict_hit, 5);
    chk(cnt_miss == 8, "R8", "miss count", cnt_miss, 8);

    // R10: reset in the middle of use clears counters and contents
    rst_n = 1'b0;
    @(negedge clk);
    chk(cnt_prim_hit == 0 && cnt_vict_hit == 0 && cnt_miss == 0, "R10", "counters cleared",
        cnt_prim_hit + cnt_vict_hit + cnt_miss, 0);
    chk(req_ready == 1'b0, "R10", "ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_access(32'h0000_1000, 2, "R10 line cleared");
    do_access(32'h0000_9000, 2, "R10 buffer cleared");
    do_access(32'h0000_1014, 1, "R4 evicted line buffered");
    @(negedge clk);
    chk(cnt_miss == 2 && cnt_vict_hit == 1 && cnt_prim_hit == 0, "R8", "counts after reset",
        {cnt_prim_hit, cnt_vict_hit, cnt_miss}, {16'd0, 16'd1, 16'd2});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule